// File: doc/BRIEF.md
# Weighted State-Register Fault Injector

This block produces single-bit upsets for a set of state machines under test. A shared 16-position target space is split into slices, one for each machine, and each slice is as wide as that machine's state register. A fault event picks one position of the space pseudo-randomly, so a machine with a wider register is hit in proportion to its width. Positions that lie beyond the last slice reach no machine. A reference machine compared against the others is simply left unconnected, so it never receives a fault.

Faults are timed by an interval counter that runs while the block is enabled. The target is taken from a 16-bit maximal-length LFSR. The operating mode decides where the flip lands. In synchronous mode it goes onto a mask that the machine XORs into its next-state value, and it lasts one clock. In asynchronous mode it goes onto a mask that the machine XORs onto its register output, and it persists for several clocks. In pulse mode it goes onto the same output-side mask for a single clock.

Top module: `seu_fault_injector`

## Requirements
- R1: While reset is held and after it is released, every output bit is zero. Reset loads the LFSR with 16'hACE1.
- R2: While enabled with rate value P (P ≥ 1), a fault event occurs on the P-th, 2P-th, 3P-th... enabled clock edge counted since enable was last low or since reset. A rate value of 0 selects the default interval of 199 clocks.
- R3: The LFSR shifts left once on every enabled clock edge, and its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10 (polynomial x^16+x^14+x^13+x^11+1). A fault event targets the position given by bits [3:0] of the LFSR value held just before that edge. The LFSR is never zero.
- R4: Machine k owns the positions off_k to off_k+w_k-1, where w_k is its width and off_k is the sum of the widths of machines 0 to k-1. Position off_k+j appears on bit j of that machine's outputs. Output bits at or above w_k stay zero, and positions at or beyond the total width reach no machine.
- R5: Across both output buses and all machines, at most one bit is high at any time.
- R6: Mode 0 (synchronous): after the event edge, the targeted bit is high on sync_flip_o for exactly one clock. async_flip_o stays zero.
- R7: Mode 1 (asynchronous): after the event edge, the targeted bit is high on async_flip_o for ASYNC_HOLD clocks (default 4). A new event during that time replaces the bit and restarts the count.
- R8: Mode 2 (pulse): after the event edge, the targeted bit is high on async_flip_o for exactly one clock.
- R9: Mode 3 (idle): events flip nothing and clear any active fault. The interval counter and the LFSR keep running.
- R10: On the edge where enable is sampled low, all outputs go to zero, and the LFSR keeps its value while enable stays low. The interval restarts when enable returns.
- R11: The mode is sampled only at the event edge. An event in one mode replaces a fault still active from another mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables fault generation |
| mode_i | input | 2 | 0 synchronous, 1 asynchronous, 2 pulse, 3 idle |
| rate_i | input | RATE_W (16) | Mean clocks between faults; 0 selects DEF_RATE |
| sync_flip_o | output | NUM_SM x MAX_W (4x8) | Per-machine mask for the next-state value |
| async_flip_o | output | NUM_SM x MAX_W (4x8) | Per-machine mask for the register output |

## Verification
The case where a new fault event lands while an earlier asynchronous fault is still being held is the one that needs care. With a hold of 4 clocks and a rate of 3, each event arrives one clock before the previous hold expires. The bench checks that the old bit disappears in that same cycle, that the new bit takes its place for a full fresh hold, and that no cycle shows two bits at once. A second sequence changes the mode between events, so that a synchronous or pulse event cuts short an asynchronous hold. In that sequence the expected mask is rebuilt each cycle from the LFSR polynomial and the slice offsets.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int unsigned SPACE_W = 16;
  localparam int unsigned IDX_W   = 4;

  typedef enum logic [1:0] {
    FI_SYNC  = 2'd0,
    FI_ASYNC = 2'd1,
    FI_PULSE = 2'd2,
    FI_IDLE  = 2'd3
  } fi_mode_e;
endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  output logic [fi_pkg::IDX_W-1:0] idx_o
);
  logic [15:0] lfsr_q;
  logic        fb;

  assign fb    = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign idx_o = lfsr_q[fi_pkg::IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lfsr_q <= SEED;
    else if (en_i) lfsr_q <= {lfsr_q[14:0], fb};
  end

  assert_lfsr_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != 16'h0);

  assert_lfsr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(lfsr_q));
endmodule

// File: rtl/fi_timer.sv
module fi_timer #(
  parameter int unsigned RATE_W   = 16,
  parameter int unsigned DEF_RATE = 199
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              fire_o
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] period;

  assign period = (rate_i == '0) ? RATE_W'(DEF_RATE) : rate_i;
  // >= keeps the counter bounded if the rate shrinks mid-interval
  assign fire_o = en_i && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_fire_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && period > 1) |=> (!fire_o || !$stable(rate_i)));

  assert_no_fire_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !fire_o);
endmodule

// File: rtl/fi_mask_gen.sv
module fi_mask_gen
  import fi_pkg::*;
#(
  parameter int unsigned ASYNC_HOLD = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fire_i,
  input  fi_mode_e           mode_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [SPACE_W-1:0] sync_flat_o,
  output logic [SPACE_W-1:0] async_flat_o
);
  localparam int unsigned HW = (ASYNC_HOLD < 2) ? 1 : $clog2(ASYNC_HOLD);

  logic [SPACE_W-1:0] mask_q, onehot;
  logic               is_sync_q;
  logic [HW-1:0]      hold_q;

  assign onehot = SPACE_W'(1) << idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      is_sync_q <= 1'b0;
      hold_q    <= '0;
    end else if (!en_i) begin
      mask_q    <= '0;
      is_sync_q <= 1'b0;
      hold_q    <= '0;
    end else if (fire_i) begin
      unique case (mode_i)
        FI_SYNC: begin
          mask_q    <= onehot;
          is_sync_q <= 1'b1;
          hold_q    <= '0;
        end
        FI_ASYNC: begin
          mask_q    <= onehot;
          is_sync_q <= 1'b0;
          hold_q    <= HW'(ASYNC_HOLD - 1);
        end
        FI_PULSE: begin
          mask_q    <= onehot;
          is_sync_q <= 1'b0;
          hold_q    <= '0;
        end
        default: begin
          mask_q    <= '0;
          is_sync_q <= 1'b0;
          hold_q    <= '0;
        end
      endcase
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else begin
      mask_q    <= '0;
      is_sync_q <= 1'b0;
    end
  end

  assign sync_flat_o  = is_sync_q ? mask_q : '0;
  assign async_flat_o = is_sync_q ? '0 : mask_q;

  assert_single_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sync_flat_o, async_flat_o}));

  assert_sync_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_flat_o != '0) |-> $past(fire_i && mode_i == FI_SYNC));

  assert_hold_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(hold_q) < ASYNC_HOLD || hold_q == '0);

  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (mask_q == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && mode_i == FI_IDLE) |=> (mask_q == '0));
endmodule

// File: rtl/fi_slicer.sv
module fi_slicer
  import fi_pkg::*;
#(
  parameter int unsigned               NUM_SM = 4,
  parameter int unsigned               MAX_W  = 8,
  parameter logic [NUM_SM-1:0][7:0]    SM_W   = {8'd5, 8'd4, 8'd3, 8'd2}
) (
  input  logic [SPACE_W-1:0]           flat_i,
  output logic [NUM_SM-1:0][MAX_W-1:0] sm_o
);
  function automatic int off_of(int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += int'(SM_W[i]);
    return s;
  endfunction

  function automatic logic [SPACE_W-1:0] owned_mask();
    logic [SPACE_W-1:0] m = '0;
    for (int i = 0; i < int'(SPACE_W); i++) m[i] = (i < off_of(NUM_SM));
    return m;
  endfunction

  localparam logic [SPACE_W-1:0] OWNED = owned_mask();

  // positions beyond the last slice hit nothing
  logic unused_spare;
  assign unused_spare = ^(flat_i & ~OWNED);

  for (genvar k = 0; k < int'(NUM_SM); k++) begin : g_sm
    localparam int OFF = off_of(k);
    localparam int W   = int'(SM_W[k]);
    for (genvar j = 0; j < int'(MAX_W); j++) begin : g_bit
      if (j < W && OFF + j < int'(SPACE_W)) begin : g_map
        assign sm_o[k][j] = flat_i[OFF+j];
      end else begin : g_zero
        assign sm_o[k][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/seu_fault_injector.sv
module seu_fault_injector
  import fi_pkg::*;
#(
  parameter int unsigned            NUM_SM     = 4,
  parameter int unsigned            MAX_W      = 8,
  parameter logic [NUM_SM-1:0][7:0] SM_W       = {8'd5, 8'd4, 8'd3, 8'd2},
  parameter int unsigned            RATE_W     = 16,
  parameter int unsigned            DEF_RATE   = 199,
  parameter int unsigned            ASYNC_HOLD = 4,
  parameter logic [15:0]            SEED       = 16'hACE1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic [1:0]                     mode_i,
  input  logic [RATE_W-1:0]              rate_i,
  output logic [NUM_SM-1:0][MAX_W-1:0]   sync_flip_o,
  output logic [NUM_SM-1:0][MAX_W-1:0]   async_flip_o
);
  logic               fire;
  logic [IDX_W-1:0]   idx;
  logic [SPACE_W-1:0] sync_flat, async_flat;

  fi_timer #(.RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) i_timer (
    .clk_i, .rst_ni, .en_i, .rate_i, .fire_o(fire)
  );

  fi_lfsr #(.SEED(SEED)) i_lfsr (
    .clk_i, .rst_ni, .en_i, .idx_o(idx)
  );

  fi_mask_gen #(.ASYNC_HOLD(ASYNC_HOLD)) i_mask (
    .clk_i, .rst_ni, .en_i,
    .fire_i       (fire),
    .mode_i       (fi_mode_e'(mode_i)),
    .idx_i        (idx),
    .sync_flat_o  (sync_flat),
    .async_flat_o (async_flat)
  );

  fi_slicer #(.NUM_SM(NUM_SM), .MAX_W(MAX_W), .SM_W(SM_W)) i_slice_sync (
    .flat_i(sync_flat), .sm_o(sync_flip_o)
  );

  fi_slicer #(.NUM_SM(NUM_SM), .MAX_W(MAX_W), .SM_W(SM_W)) i_slice_async (
    .flat_i(async_flat), .sm_o(async_flip_o)
  );

  assert_outputs_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((sync_flip_o != '0) && (async_flip_o != '0)));

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sync_flip_o == '0 && async_flip_o == '0));
endmodule

// File: tb/test_seu_fault_injector.sv
module test_seu_fault_injector;
  localparam int NUM_SM = 4;
  localparam int MAX_W  = 8;
  localparam int HOLD   = 4;
  localparam logic [NUM_SM-1:0][7:0] WID = {8'd5, 8'd4, 8'd3, 8'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [15:0] rate = 16'd5;
  logic [NUM_SM-1:0][MAX_W-1:0] sync_o, async_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_lfsr;
  int          m_k;
  logic [15:0] m_flat;
  bit          m_sync;
  int          m_left;

  always #5 clk = ~clk;

  seu_fault_injector i_seu_fault_injector (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .rate_i(rate),
    .sync_flip_o(sync_o), .async_flip_o(async_o)
  );

  function automatic logic [15:0] step(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic int offset(int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += int'(WID[i]);
    return s;
  endfunction

  function automatic logic [15:0] owned();
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) m[i] = (i < offset(NUM_SM));
    return m;
  endfunction

  function automatic logic [15:0] gather(logic [NUM_SM-1:0][MAX_W-1:0] v);
    logic [15:0] f = '0;
    for (int k = 0; k < NUM_SM; k++)
      for (int j = 0; j < int'(WID[k]); j++) f[offset(k)+j] = v[k][j];
    return f;
  endfunction

  function automatic int stray(logic [NUM_SM-1:0][MAX_W-1:0] v);
    int n = 0;
    for (int k = 0; k < NUM_SM; k++)
      for (int j = int'(WID[k]); j < MAX_W; j++) n += int'(v[k][j]);
    return n;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 0;
    rst_n = 0;
    @(negedge clk);
    chk(sync_o == '0 && async_o == '0, "R1 reset outputs", gather(sync_o) | gather(async_o), 16'h0);
    @(negedge clk);
    rst_n = 1;
    m_lfsr = 16'hACE1; m_k = 0; m_flat = '0; m_sync = 0; m_left = 0;
    @(negedge clk);
    chk(sync_o == '0 && async_o == '0, "R1 after release", gather(sync_o) | gather(async_o), 16'h0);
  endtask

  // drive for n cycles, predict and compare after every edge
  task automatic run(bit e, logic [1:0] md, logic [15:0] rt, int n, string tag);
    int p;
    en = e; mode = md; rate = rt;
    p = (rt == 0) ? 199 : int'(rt);
    for (int c = 0; c < n; c++) begin
      logic [15:0] es, ea;
      @(posedge clk);
      if (!e) begin
        m_k = 0; m_flat = '0; m_sync = 0; m_left = 0;
      end else begin
        m_k++;
        if (m_k % p == 0) begin
          logic [15:0] oh = 16'h1 << m_lfsr[3:0];
          case (md)
            2'd0: begin m_flat = oh; m_sync = 1; m_left = 1; end
            2'd1: begin m_flat = oh; m_sync = 0; m_left = HOLD; end
            2'd2: begin m_flat = oh; m_sync = 0; m_left = 1; end
            default: begin m_flat = '0; m_sync = 0; m_left = 0; end
          endcase
        end else if (m_left > 0) begin
          m_left--;
          if (m_left == 0) begin m_flat = '0; m_sync = 0; end
        end
        m_lfsr = step(m_lfsr);
      end
      @(negedge clk);
      es = m_sync ? (m_flat & owned()) : 16'h0;
      ea = m_sync ? 16'h0 : (m_flat & owned());
      chk(gather(sync_o) == es, {tag, " sync bus"}, gather(sync_o), es);
      chk(gather(async_o) == ea, {tag, " async bus"}, gather(async_o), ea);
      chk(stray(sync_o) + stray(async_o) == 0, "R4 bits above width", 16'(stray(sync_o) + stray(async_o)), 16'h0);
      chk($countones({gather(sync_o), gather(async_o)}) <= 1, "R5 single bit",
          gather(sync_o) | gather(async_o), m_flat);
    end
  endtask

  task automatic t_sync();   do_reset(); run(1, 2'd0, 16'd5, 80, "R6 R3 R4 sync");      endtask
  task automatic t_async();  do_reset(); run(1, 2'd1, 16'd10, 60, "R7 async hold");     endtask
  task automatic t_overlap();do_reset(); run(1, 2'd1, 16'd3, 40, "R7 R5 overlap");      endtask
  task automatic t_pulse();  do_reset(); run(1, 2'd2, 16'd4, 40, "R8 pulse");           endtask
  task automatic t_rate1();  do_reset(); run(1, 2'd0, 16'd1, 24, "R2 every clock");     endtask
  task automatic t_default();do_reset(); run(1, 2'd0, 16'd0, 420, "R2 default rate");   endtask

  task automatic t_idle();
    do_reset();
    run(1, 2'd3, 16'd2, 21, "R9 idle");
    run(1, 2'd0, 16'd2, 20, "R9 lfsr advanced in idle");
  endtask

  task automatic t_enable();
    do_reset();
    run(1, 2'd1, 16'd3, 7, "R10 before disable");
    run(0, 2'd1, 16'd3, 6, "R10 disabled");
    run(1, 2'd0, 16'd3, 16, "R10 restart");
  endtask

  task automatic t_mixed();
    do_reset();
    run(1, 2'd1, 16'd3, 5, "R11 async");
    run(1, 2'd0, 16'd3, 1, "R11 sync replaces");
    run(1, 2'd1, 16'd3, 5, "R11 async again");
    run(1, 2'd2, 16'd3, 4, "R11 pulse replaces");
    run(1, 2'd3, 16'd3, 4, "R11 R9 idle clears");
    run(1, 2'd1, 16'd3, 10, "R11 final");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_sync();
    t_async();
    t_overlap();
    t_pulse();
    t_rate1();
    t_idle();
    t_enable();
    t_mixed();
    t_default();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule